// File: doc/BRIEF.md
# MII Management Serial Master

This block runs one PHY register access at a time over the two-wire management link: a clock it generates (`mdc`) and a shared data line that it drives through `mdio_o`/`mdio_oe` and reads back on `mdio_i`. A command carries the direction, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block expands it into a full frame. The frame starts with a run of ones that lets the PHYs lock on. A header follows, then either the write turnaround and data or a released line from which the read result is taken. One extra clock closes the frame. When the PHY fails to acknowledge a read, the block still clocks out the whole data field so that every PHY on the link stays in step. It then reports an error.

Commands enter on a valid/ready handshake. A command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low for the whole time a frame is in flight, so a request raised and withdrawn during that time has no effect. A request still held when the frame ends is taken as the next command. Results are plain status pins: `done` pulses for one cycle, and `rsp_rdata`/`rsp_err` hold their values until the next command is accepted.

The management clock's half period is `cfg_half_period` system clock cycles. The value is sampled when the command is accepted, and zero counts as one. Each bit slot is one low half followed by one high half. Every frame, read or write, has 65 slots.

Top module: `mdio_master`

## Requirements
- R1: Slots 0 to 31 of every frame drive the data line high (`mdio_oe`=1, `mdio_o`=1).
- R2: Slots 32 to 45 drive the start code 01, then the opcode (read 10, write 01), then the PHY address, then the register address, each field most significant bit first.
- R3: A write drives the turnaround 10 in slots 46 and 47, then the 16 data bits MSB first in slots 48 to 63, then a high idle bit in slot 64. A frame has exactly 65 rising clock edges.
- R4: A read releases the line (`mdio_oe`=0) from slot 46 to the end of the frame. The acknowledge is the value of `mdio_i` at the rising clock edge of slot 47.
- R5: When the acknowledge is low, a read captures `mdio_i` at the rising edges of slots 48 to 63, MSB first, into `rsp_rdata`, and `rsp_err` is 0.
- R6: When the acknowledge is high, the frame still runs its full 65 clocks, `rsp_err` is 1 and `rsp_rdata` is 0.
- R7: `mdc` is low for H cycles and then high for H cycles in each slot. H is `cfg_half_period` sampled at acceptance, with 0 treated as 1. `mdio_o` and `mdio_oe` change only when `mdc` falls or the frame starts. `done` goes high 130·H cycles after the accepting edge.
- R8: `busy` is high from the cycle after acceptance until `done`. `cmd_ready` is low while `busy` is high, and a `cmd_valid` pulse during that time starts no frame.
- R9: `done` is a single-cycle pulse. From that cycle on, `mdc` and `mdio_oe` are low, and `rsp_rdata`/`rsp_err` hold their values. A write returns `rsp_rdata`=0 and `rsp_err`=0.
- R10: After reset, `busy`, `done`, `mdc`, `mdio_oe`, `rsp_err` and `rsp_rdata` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half_period | input | DIV_W | Management clock half period in system cycles, 0 acts as 1 |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can take a command |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rsp_rdata | output | 16 | Read result |
| rsp_err | output | 1 | PHY did not acknowledge the read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Let the accepting edge be cycle 0. With half period H, `mdc` rises at cycle (2s+1)·H for slot s and falls at (2s+2)·H. `done` is visible right after cycle 130·H, and `busy` one cycle after acceptance. The bench samples on the falling system-clock edge and counts those edges from the acceptance. A rising edge of `mdc` is credited to the count at which it first appears, which must be exactly H more, then 2·H more each time, than the previous one. The PHY model changes `mdio_i` only right after a rise, so the value is settled long before the next rise samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned SLOT_W    = 7;
  localparam int unsigned FRAME_W   = 64;
  localparam logic [SLOT_W-1:0] SL_PRE  = 7'd32; // first header slot
  localparam logic [SLOT_W-1:0] SL_REL  = 7'd46; // first released slot on reads
  localparam logic [SLOT_W-1:0] SL_ACK  = 7'd47;
  localparam logic [SLOT_W-1:0] SL_DAT0 = 7'd48;
  localparam logic [SLOT_W-1:0] SL_DATN = 7'd63;
  localparam logic [SLOT_W-1:0] SL_IDLE = 7'd64;

  localparam logic [1:0] CODE_SOF = 2'b01;
  localparam logic [1:0] CODE_RD  = 2'b10;
  localparam logic [1:0] CODE_WR  = 2'b01;
  localparam logic [1:0] CODE_TA  = 2'b10;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mgmt_cmd_t;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} mdc_phase_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt;
  logic             last;

  assign last = (cnt == (half - ONE));
  assign tick = run && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || last)   cnt <= '0;
    else                     cnt <= cnt + ONE;
  end

  // R7: the phase counter never passes the programmed half period
  assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half));
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
(
  input  mgmt_cmd_t          cmd,
  output logic [FRAME_W-1:0] frame
);
  logic [1:0]  op;
  logic [1:0]  ta;
  logic [15:0] dat;

  always_comb begin
    op    = cmd.wr ? CODE_WR : CODE_RD;
    ta    = cmd.wr ? CODE_TA : 2'b11;
    dat   = cmd.wr ? cmd.wdata : 16'hFFFF;
    frame = {32'hFFFF_FFFF, CODE_SOF, op, cmd.phy, cmd.regad, ta, dat};
  end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              is_read,
  input  logic [SLOT_W-1:0] slot,
  input  logic              mdio_i,
  output logic [15:0]       rdata,
  output logic              nack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      nack  <= 1'b0;
    end else if (clear) begin
      rdata <= '0;
      nack  <= 1'b0;
    end else if (sample && is_read) begin
      if (slot == SL_ACK)
        nack <= mdio_i;
      else if (slot >= SL_DAT0 && slot <= SL_DATN && !nack)
        rdata <= {rdata[14:0], mdio_i};
    end
  end

  // R6: an unacknowledged read never collects data bits
  assert_nack_no_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> (rdata == 16'h0000));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_half_period,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [4:0]       cmd_phy,
  input  logic [4:0]       cmd_reg,
  input  logic [15:0]      cmd_wdata,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rsp_rdata,
  output logic             rsp_err,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam logic [DIV_W-1:0] HALF_MIN = {{(DIV_W-1){1'b0}}, 1'b1};

  mgmt_cmd_t          cmd_in;
  logic [FRAME_W-1:0] frame_w;
  logic [FRAME_W-1:0] shreg;
  logic [SLOT_W-1:0]  slot;
  logic [SLOT_W-1:0]  slot_nxt;
  logic [DIV_W-1:0]   half_q;
  mdc_phase_e         phase;
  logic               wr_q;
  logic               accept;
  logic               tick;
  logic               rise;

  assign cmd_in   = '{wr: cmd_write, phy: cmd_phy, regad: cmd_reg, wdata: cmd_wdata};
  assign cmd_ready = !busy;
  assign accept   = cmd_valid && !busy;
  assign slot_nxt = slot + 1'b1;
  assign rise     = busy && tick && (phase == PH_LOW);
  assign mdio_o   = shreg[FRAME_W-1];

  mdio_frame_build u_build (
    .cmd   (cmd_in),
    .frame (frame_w)
  );

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .half  (half_q),
    .tick  (tick)
  );

  mdio_rx_capture u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .sample  (rise),
    .is_read (!wr_q),
    .slot    (slot),
    .mdio_i  (mdio_i),
    .rdata   (rsp_rdata),
    .nack    (rsp_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      phase   <= PH_LOW;
      slot    <= '0;
      shreg   <= '1;
      wr_q    <= 1'b0;
      half_q  <= HALF_MIN;
      mdc     <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        phase   <= PH_LOW;
        slot    <= '0;
        shreg   <= frame_w;
        wr_q    <= cmd_write;
        half_q  <= (cfg_half_period == '0) ? HALF_MIN : cfg_half_period;
        mdc     <= 1'b0;
        mdio_oe <= 1'b1;
      end else if (busy && tick) begin
        if (phase == PH_LOW) begin
          phase <= PH_HIGH;
          mdc   <= 1'b1;
        end else begin
          phase <= PH_LOW;
          mdc   <= 1'b0;
          if (slot == SL_IDLE) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
          end else begin
            slot    <= slot_nxt;
            shreg   <= {shreg[FRAME_W-2:0], 1'b1};
            mdio_oe <= wr_q || (slot_nxt < SL_REL);
          end
        end
      end
    end
  end

  // R1: preamble slots drive ones
  assert_preamble_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot < SL_PRE) |-> (mdio_oe && mdio_o));

  // R3: the slot index never passes the idle slot
  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SL_IDLE);

  // R4: reads leave the line to the PHY from the turnaround on
  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_q && slot >= SL_REL) |-> !mdio_oe);

  // R7: the management clock moves only on divider ticks
  assert_mdc_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(mdc));

  // R8: an accepted command makes the block busy
  assert_accept_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  // R9: at the end pulse the link is quiet
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mdio_oe && !mdc));
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_half_period = '0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic             cmd_write = 1'b0;
  logic [4:0]       cmd_phy = '0;
  logic [4:0]       cmd_reg = '0;
  logic [15:0]      cmd_wdata = '0;
  logic             busy, done, rsp_err, mdc, mdio_o, mdio_oe;
  logic [15:0]      rsp_rdata;
  logic             mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mdio_master #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_half_period(cfg_half_period),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic phy_bit(input int s, input bit nack, input logic [15:0] pd);
    if (s == 47) return nack;
    if (s >= 48 && s <= 63) return nack ? 1'b1 : pd[63-s];
    return 1'b1;
  endfunction

  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input int h, input bit nack,
                         input logic [15:0] pd, input bit poke);
    logic [63:0] exp_f;
    logic [64:0] got_oe, got_d;
    int eff_h, rises, n, done_at, last_rise, per_bad, viol;
    bit prev_mdc, prev_oe, prev_o, pre_ok, hdr_ok, tail_ok;
    eff_h = (h == 0) ? 1 : h;
    exp_f = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
             (wr ? 2'b10 : 2'b11), (wr ? wd : 16'hFFFF)};
    got_oe = '0; got_d = '0;
    rises = 0; done_at = -1; last_rise = -eff_h; per_bad = 0; viol = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    cfg_half_period = DIV_W'(h); mdio_i = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_write = ~wr; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
    cfg_half_period = DIV_W'(5);  // R7: must not affect the running frame
    chk(busy == 1'b1, "R8", "busy after accept", longint'(busy), 1);
    n = 0;
    prev_mdc = mdc; prev_oe = mdio_oe; prev_o = mdio_o;
    while (done_at < 0 && n < 200 * eff_h + 20) begin
      @(negedge clk);
      n++;
      if (poke && n == 10) begin
        chk(cmd_ready == 1'b0, "R8", "ready while busy", longint'(cmd_ready), 0);
        cmd_valid = 1'b1;
      end
      if (poke && n == 11) cmd_valid = 1'b0;
      if (mdc && !prev_mdc) begin
        if (rises <= 64) begin got_oe[rises] = mdio_oe; got_d[rises] = mdio_o; end
        if (n - last_rise != 2 * eff_h) per_bad++;
        last_rise = n;
        rises++;
        mdio_i = phy_bit(rises, nack, pd);
      end
      if (prev_mdc && mdc && (mdio_oe != prev_oe || (mdio_oe && mdio_o != prev_o))) viol++;
      if (done) done_at = n;
      prev_mdc = mdc; prev_oe = mdio_oe; prev_o = mdio_o;
    end
    mdio_i = 1'b1;
    pre_ok = 1'b1; hdr_ok = 1'b1; tail_ok = 1'b1;
    for (int s = 0; s < 32; s++) if (!(got_oe[s] && got_d[s])) pre_ok = 1'b0;
    for (int s = 32; s < 46; s++) if (!(got_oe[s] && got_d[s] == exp_f[63-s])) hdr_ok = 1'b0;
    for (int s = 46; s < 65; s++) begin
      if (wr) begin
        if (!(got_oe[s] && got_d[s] == ((s == 64) ? 1'b1 : exp_f[63-s]))) tail_ok = 1'b0;
      end else if (got_oe[s]) tail_ok = 1'b0;
    end
    chk(pre_ok, "R1", "preamble driven high", longint'(pre_ok), 1);
    chk(hdr_ok, "R2", "start/op/addresses", longint'(hdr_ok), 1);
    if (wr) chk(tail_ok, "R3", "turnaround/data/idle", longint'(tail_ok), 1);
    else    chk(tail_ok, "R4", "line released on read", longint'(tail_ok), 1);
    chk(rises == 65, nack ? "R6" : "R3", "rising edges per frame", rises, 65);
    chk(done_at == 130 * eff_h, "R7", "done cycle", done_at, 130 * eff_h);
    chk(per_bad == 0, "R7", "mdc half-period spacing", per_bad, 0);
    chk(viol == 0, "R7", "line changed while mdc high", viol, 0);
    if (wr) begin
      chk(rsp_rdata == 16'h0 && !rsp_err, "R9", "write result", {rsp_err, rsp_rdata}, 0);
    end else if (nack) begin
      chk(rsp_err == 1'b1, "R6", "nack error flag", longint'(rsp_err), 1);
      chk(rsp_rdata == 16'h0, "R6", "nack read data", rsp_rdata, 0);
    end else begin
      chk(rsp_err == 1'b0, "R5", "ack error flag", longint'(rsp_err), 0);
      chk(rsp_rdata == pd, "R5", "read data", rsp_rdata, pd);
    end
    @(negedge clk);
    chk(!done && !busy && !mdc && !mdio_oe, "R9", "quiet after done",
        {done, busy, mdc, mdio_oe}, 0);
    chk(cmd_ready == 1'b1, "R8", "ready after done", longint'(cmd_ready), 1);
    if (poke) begin
      for (int k = 0; k < 4 * eff_h + 4; k++) begin
        @(negedge clk);
        if (busy || mdc) begin
          chk(1'b0, "R8", "ignored request started a frame", {busy, mdc}, 0);
          break;
        end
      end
      chk(rsp_err == (!wr && nack), "R9", "result held", longint'(rsp_err),
          longint'(!wr && nack));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !mdc && !mdio_oe && !rsp_err && rsp_rdata == 0 && cmd_ready,
        "R10", "reset outputs", {busy, done, mdc, mdio_oe, rsp_err, rsp_rdata}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int h = 0; h < 4; h++) begin
      run_txn(1'b1, 5'(h * 7 + 3), 5'(31 - h * 5), 16'hA5C3 ^ 16'(h * 16'h1111), h, 1'b0, 16'h0, h == 1);
      run_txn(1'b0, 5'(h * 9 + 1), 5'(h * 4 + 2), 16'h0, h, 1'b0, 16'h3C96 ^ 16'(h * 16'h0F0F), h == 2);
      run_txn(1'b0, 5'(h + 17), 5'(h * 3), 16'h0, h, 1'b1, 16'h1234, h == 3);
    end
    run_txn(1'b1, 5'd0, 5'd31, 16'hFFFF, 2, 1'b0, 16'h0, 1'b0);
    run_txn(1'b1, 5'd31, 5'd0, 16'h0000, 1, 1'b0, 16'h0, 1'b0);
    run_txn(1'b0, 5'd31, 5'd31, 16'h0, 1, 1'b0, 16'hFFFF, 1'b0);
    run_txn(1'b0, 5'd0, 5'd0, 16'h0, 3, 1'b0, 16'h8001, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule